// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial EEPROM. It watches the sampled levels of the clock line (`scl_i`) and the data line (`sda_i`) once per system clock. It finds start and stop conditions and counts bus clock cycles inside a transfer. It latches command, device and word-address bits, shifts write data into an internal byte array, and drives one data output bit (`sda_o`) for acknowledge and read data. The output is meant to be combined onto the shared data line by the surrounding logic.

A static protocol select input chooses one of three framings:
- a single command byte that carries a 7-bit word address together with the read/write flag;
- a device byte followed by one word-address byte;
- a device byte followed by two word-address bytes.

Sequential reads and page writes follow the address-advance rules of each framing. The next read bit is already on the output while the clock line is still low, so a host that samples early gets correct data.

Top module: `eeprom_2wire_slave`

## Requirements
- R1: A start condition is seen when `sda_i` falls while `scl_i` is high on both the previous and the current sample. It marks the block as started and clears the bus cycle count. The word address is kept, so a read issued right after a fresh start continues from the current address.
- R2: A stop condition is seen when `sda_i` rises while `scl_i` stays high. It ends the transfer. After it, `sda_o` again echoes the last `sda_i` level even while the clock keeps toggling.
- R3: Only while started does each `scl_i` rising edge advance the cycle count, with data bits taken on the following falling edge. Clocking bits with no start leaves the array unchanged.
- R4: With `proto_i`=00, cycles 1 to 8 carry one byte. Bits 7:1 of that byte are the word address and bit 0 is the read flag (1 = read). Cycle 9 is the acknowledge. Each following group of 8 write bits fills the addressed byte, MSB first. After each byte only address bits 1:0 advance, giving a 4-byte page.
- R5: With `proto_i`=00 and the read flag set, each byte is followed by an acknowledge cycle. The 7-bit word address then advances modulo 128.
- R6: With `proto_i`=01, the device byte (bit 0 = read flag) is followed by one 8-bit word-address byte. Device-byte bits 3:1 become address bits 10:8. On writes only address bits 3:0 advance after each byte (16-byte page).
- R7: With `proto_i`=10, the device byte is followed by two word-address bytes, sent high byte first and kept as a 13-bit address. On writes only address bits 3:0 advance after each byte.
- R8: In both device modes, a read returns data from the current word address, MSB first. After each byte the address advances across pages and wraps modulo 2^13. The array is indexed by the low 11 address bits.
- R9: `sda_o` is driven 0 for every acknowledge cycle. This includes the clock-low time just before the acknowledge clock rises.
- R10: When not started, or when the block is not driving ack or read data, `sda_o` echoes the last sampled `sda_i` level.
- R11: Each read bit is valid on `sda_o` while `scl_i` is still low before its clock rises, and it stays the same while `scl_i` is high.
- R12: After reset `sda_o` is 1 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| proto_i | input | 2 | Framing select: 00 command byte, 01 device + one address byte, 10 device + two address bytes; static during a transfer |
| scl_i | input | 1 | Synchronized level of the bus clock line |
| sda_i | input | 1 | Synchronized level of the bus data line |
| sda_o | output | 1 | Data line value driven by the slave (0 = pull low) |

## Verification
The bench writes across a page end in each framing and reads back the bytes on both sides of it. A design that carried the page increment into the upper address bits would leave the byte after the page end written and the first byte of the page untouched. Sequential reads are run across a 7-bit wrap and across the 13-bit wrap, where a wrong mask would return the wrong byte after the wrap. Each read bit is taken both before and after its clock rises, so a design that only updated the output on the rising edge shows a mismatch. The bench also checks that the ack is low before the ninth clock rises and that the output falls back to echoing the data line after a stop. It checks that the device-select bits land in address bits 10:8 by reading the same byte through the two-address-byte framing.

// File: rtl/eeprom_slave_pkg.sv
// Shared definitions for the two-wire EEPROM slave.
// Assumes: protocol select is static for the duration of a transfer.
package eeprom_slave_pkg;

    typedef enum logic [1:0] {
        PROTO_CMDBYTE = 2'b00,   // one byte: 7-bit word address + read flag
        PROTO_DEV_A8  = 2'b01,   // device byte + one word-address byte
        PROTO_DEV_A16 = 2'b10    // device byte + two word-address bytes
    } proto_e;

    localparam int unsigned CYC_W  = 6;   // bus cycle counter width
    localparam int unsigned WADR_W = 13;  // device-mode word address width

    // Cycle count after an SCL rising edge, including the wrap-back points
    function automatic logic [CYC_W-1:0] cyc_advance(
        input logic [CYC_W-1:0] cur,
        input logic [1:0]       proto,
        input logic             rd
    );
        logic [CYC_W-1:0] nxt;
        nxt = cur + 6'd1;
        if (proto == PROTO_CMDBYTE) begin
            if (nxt == 6'd18) nxt = 6'd9;
        end else if (rd && nxt == 6'd18) begin
            nxt = 6'd9;
        end else if (proto == PROTO_DEV_A8 && nxt == 6'd27) begin
            nxt = 6'd18;
        end else if (nxt == 6'd36) begin
            nxt = 6'd27;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/twi_line_sampler.sv
// Registers the bus line levels and flags start, stop and clock edges.
// Assumes: scl_i and sda_i are already synchronized to clk.
module twi_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);

    // Hold the previous sample of both lines (idle bus is high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify the transition between previous and current samples
    always_comb begin
        start_ev = scl_q & scl_i & sda_q & ~sda_i;
        stop_ev  = scl_q & scl_i & ~sda_q & sda_i;
        rise_ev  = ~scl_q & scl_i;
        fall_ev  = scl_q & ~scl_i;
    end

endmodule

// File: rtl/xfer_sequencer.sv
// Transfer state: started flag, bus cycle count, command/device byte,
// word address and the write strobe into the byte array.
// Assumes: proto_i is static while started; IDX_W is between 7 and 13.
module xfer_sequencer
    import eeprom_slave_pkg::*;
#(
    parameter int unsigned IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       proto_i,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             rise_ev,
    input  logic             fall_ev,
    input  logic             sda_bit,
    output logic             started,
    output logic [CYC_W-1:0] cyc,
    output logic             rd_flag,
    output logic [IDX_W-1:0] mem_idx,
    output logic             wr_en
);

    logic [7:0]        cmd;     // command-byte mode: addr[7:1], read flag[0]
    logic [7:0]        dev;     // device byte: select bits [3:1], read flag[0]
    logic [WADR_W-1:0] waddr;   // device-mode word address
    logic              legacy;
    logic              a8;
    logic              in_data;
    logic              is_ack;
    logic [CYC_W-1:0]  cyc_up;

    // Decode mode, direction and the write-data window of the current cycle
    always_comb begin
        legacy  = (proto_i == PROTO_CMDBYTE);
        a8      = (proto_i == PROTO_DEV_A8);
        rd_flag = legacy ? cmd[0] : dev[0];
        is_ack  = (cyc == 6'd9) || (cyc == 6'd18) || (cyc == 6'd27);
        cyc_up  = cyc_advance(cyc, proto_i, rd_flag);
        if (legacy)  in_data = (cyc >= 6'd10) && (cyc <= 6'd17);
        else if (a8) in_data = (cyc >= 6'd19) && (cyc <= 6'd26);
        else         in_data = (cyc >= 6'd28) && (cyc <= 6'd35);
        mem_idx = legacy ? IDX_W'(cmd[7:1]) : waddr[IDX_W-1:0];
        wr_en   = started & fall_ev & ~rd_flag & in_data;
    end

    // Advance the transfer on start, stop and clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            cyc     <= '0;
            cmd     <= '0;
            dev     <= '0;
            waddr   <= '0;
        end else if (start_ev) begin
            started <= 1'b1;
            cyc     <= '0;
        end else if (stop_ev) begin
            started <= 1'b0;
        end else if (started && rise_ev) begin
            cyc <= cyc_up;
            if (rd_flag && cyc == 6'd17) begin
                if (legacy) cmd[7:1] <= cmd[7:1] + 7'd1;
                else        waddr    <= waddr + 13'd1;
            end
        end else if (started && fall_ev) begin
            if (cyc >= 6'd1 && cyc <= 6'd8) begin
                if (legacy) cmd <= {cmd[6:0], sda_bit};
                else        dev <= {dev[6:0], sda_bit};
            end else if (legacy) begin
                if (!cmd[0] && cyc == 6'd17) cmd[2:1] <= cmd[2:1] + 2'd1;
            end else if (in_data) begin
                if (!dev[0] && (cyc == 6'd26 || cyc == 6'd35))
                    waddr[3:0] <= waddr[3:0] + 4'd1;
            end else if (!is_ack && cyc >= 6'd10 && !dev[0]) begin
                if (a8 && cyc == 6'd17) waddr <= {2'b00, dev[3:1], waddr[6:0], sda_bit};
                else if (a8)            waddr <= {5'b00000, waddr[6:0], sda_bit};
                else                    waddr <= {waddr[WADR_W-2:0], sda_bit};
            end
        end
    end

    // R1: a start leaves the block started with a cleared count
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (started && cyc == 6'd0));

    // R2: a stop ends the transfer
    p_stop_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !started);

    // R3: every clock rise inside a transfer moves the count
    p_count_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (started && rise_ev && !start_ev) |=> (cyc != $past(cyc)));

    // R4: command-byte framing never leaves the first wrap window
    p_cmd_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_i == PROTO_CMDBYTE) |-> (cyc < 6'd18));

    // R6: one-address-byte page write advances only the low nibble
    p_page_a8_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (started && fall_ev && a8 && !rd_flag && cyc == 6'd26) |=>
        (waddr[12:4] == $past(waddr[12:4]) && waddr[3:0] == $past(waddr[3:0]) + 4'd1));

    // R7: two-address-byte page write advances only the low nibble
    p_page_a16_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (started && fall_ev && !legacy && !a8 && !rd_flag && cyc == 6'd35) |=>
        (waddr[12:4] == $past(waddr[12:4]) && waddr[3:0] == $past(waddr[3:0]) + 4'd1));

    // R8: a device-mode read steps the full address after each byte
    p_read_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (started && rise_ev && !legacy && rd_flag && cyc == 6'd17) |=>
        (waddr == 13'($past(waddr) + 13'd1)));

endmodule

// File: rtl/byte_store.sv
// Byte array written one bit at a time by shifting the addressed byte left.
// Assumes: a single shared index for write and read; reset fills with 0xFF.
module byte_store #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       rd_byte
);

    logic [7:0] mem [DEPTH];

    // Fill on reset, otherwise shift one write bit into the addressed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[idx] <= {mem[idx][6:0], wr_bit};
        end
    end

    // Asynchronous read of the addressed byte
    always_comb rd_byte = mem[idx];

    // R3: the addressed byte only changes under a write strobe
    p_store_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> (rd_byte == $past(rd_byte) || idx != $past(idx)));

endmodule

// File: rtl/eeprom_2wire_slave.sv
// Two-wire serial EEPROM slave: samples the bus lines, sequences the
// transfer and drives ack/read data with one-cycle look-ahead while SCL is low.
// Assumes: synchronized line inputs, static proto_i during a transfer,
// and external logic that turns sda_o into an open-drain pull-down.
module eeprom_2wire_slave
    import eeprom_slave_pkg::*;
#(
    parameter int unsigned DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] proto_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic             scl_q, sda_q;
    logic             start_ev, stop_ev, rise_ev, fall_ev;
    logic             started, rd_flag, wr_en;
    logic [CYC_W-1:0] cyc;
    logic [CYC_W-1:0] look_cyc;
    logic [IDX_W-1:0] mem_idx;
    logic [7:0]       rd_byte;
    logic [2:0]       bit_pos;

    twi_line_sampler u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    xfer_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .proto_i  (proto_i),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .sda_bit  (sda_i),
        .started  (started),
        .cyc      (cyc),
        .rd_flag  (rd_flag),
        .mem_idx  (mem_idx),
        .wr_en    (wr_en)
    );

    byte_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bit  (sda_i),
        .idx     (mem_idx),
        .rd_byte (rd_byte)
    );

    // Pick the output bit, looking one cycle ahead while SCL is low
    always_comb begin
        look_cyc = scl_q ? cyc : cyc_advance(cyc, proto_i, rd_flag);
        bit_pos  = 3'd7 - 3'(look_cyc - 6'd10);
        sda_o    = sda_q;
        if (started) begin
            if (look_cyc == 6'd9 || look_cyc == 6'd18 || look_cyc == 6'd27)
                sda_o = 1'b0;
            else if (rd_flag && look_cyc >= 6'd10 && look_cyc <= 6'd17)
                sda_o = rd_byte[bit_pos];
        end
    end

    // R9: the line is held low through the high phase of the first ack clock
    p_ack_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (started && scl_q && cyc == 6'd9) |-> !sda_o);

    // R10: outside a transfer the output follows the data line one sample late
    p_idle_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && $past(rst_n)) |-> (sda_o == $past(sda_i)));

endmodule

// File: tb/tb_eeprom_2wire_slave.sv
module tb_eeprom_2wire_slave;

    localparam int CLK_PERIOD = 10;
    localparam int PH         = 4;   // system clocks per bus phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] proto = 2'b00;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       sda_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    eeprom_2wire_slave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .proto_i (proto),
        .scl_i   (scl),
        .sda_i   (sda),
        .sda_o   (sda_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_lines(logic c, logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        repeat (PH - 1) @(negedge clk);
    endtask

    task automatic bus_start();
        if (scl == 1'b0) set_lines(1'b0, 1'b1);
        set_lines(1'b1, 1'b1);
        set_lines(1'b1, 1'b0);
        set_lines(1'b0, 1'b0);
    endtask

    task automatic bus_stop();
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b0);
        set_lines(1'b1, 1'b1);
    endtask

    task automatic put_bit(logic b);
        set_lines(1'b0, b);
        set_lines(1'b1, b);
        set_lines(1'b0, b);
    endtask

    // Send a byte MSB first and check the slave ack (R9)
    task automatic put_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        set_lines(1'b0, 1'b1);
        check("R9", "ack before clock rise", {15'd0, sda_o}, 16'd0);
        set_lines(1'b1, 1'b1);
        check("R9", "ack during clock high", {15'd0, sda_o}, 16'd0);
        set_lines(1'b0, 1'b1);
    endtask

    // Receive a byte; each bit compared before and after its clock rise (R11)
    task automatic get_byte(int slot, logic nack);
        logic early;
        for (int i = 7; i >= 0; i--) begin
            set_lines(1'b0, 1'b1);
            early = sda_o;
            set_lines(1'b1, 1'b1);
            check("R11", "read bit early vs high", {15'd0, early}, {15'd0, sda_o});
            rbuf[slot][i] = sda_o;
            set_lines(1'b0, 1'b1);
        end
        set_lines(1'b0, nack);
        set_lines(1'b1, nack);
        set_lines(1'b0, nack);
        set_lines(1'b0, 1'b1);
    endtask

    task automatic legacy_write(logic [6:0] a, int n);
        bus_start();
        put_byte({a, 1'b0});
        for (int i = 0; i < n; i++) put_byte(wbuf[i]);
        bus_stop();
    endtask

    task automatic legacy_read(logic [6:0] a, int n);
        bus_start();
        put_byte({a, 1'b1});
        for (int i = 0; i < n; i++) get_byte(i, (i == n - 1));
        bus_stop();
    endtask

    task automatic dev_addr_phase(logic [2:0] sel, logic [15:0] a);
        bus_start();
        put_byte({4'hA, sel, 1'b0});
        if (proto == 2'b01) begin
            put_byte(a[7:0]);
        end else begin
            put_byte(a[15:8]);
            put_byte(a[7:0]);
        end
    endtask

    task automatic dev_write(logic [2:0] sel, logic [15:0] a, int n);
        dev_addr_phase(sel, a);
        for (int i = 0; i < n; i++) put_byte(wbuf[i]);
        bus_stop();
    endtask

    task automatic cur_read(int n);
        bus_start();
        put_byte(8'hA1);
        for (int i = 0; i < n; i++) get_byte(i, (i == n - 1));
        bus_stop();
    endtask

    task automatic dev_read(logic [2:0] sel, logic [15:0] a, int n);
        dev_addr_phase(sel, a);
        cur_read(n);
    endtask

    // R12: output idles high after reset
    task automatic t_reset();
        check("R12", "sda_o after reset", {15'd0, sda_o}, 16'd1);
    endtask

    // R10: idle output follows the data line
    task automatic t_open_bus();
        set_lines(1'b0, 1'b0);
        check("R10", "idle echo low", {15'd0, sda_o}, 16'd0);
        set_lines(1'b0, 1'b1);
        check("R10", "idle echo high", {15'd0, sda_o}, 16'd1);
    endtask

    // R3: bits clocked without a start do not write; R12: fresh byte is 0xFF
    task automatic t_no_start_ignored();
        proto = 2'b00;
        for (int i = 7; i >= 0; i--) put_bit(logic'(((8'h0A) >> i) & 1));
        for (int i = 7; i >= 0; i--) put_bit(1'b0);
        for (int i = 7; i >= 0; i--) put_bit(1'b0);
        legacy_read(7'h05, 1);
        check("R3", "byte 0x05 untouched without start", {8'd0, rbuf[0]}, 16'h00FF);
    endtask

    // R2: after a stop the output echoes again while a clock pulse follows
    task automatic t_stop_releases();
        proto = 2'b00;
        bus_start();
        put_byte({7'h05, 1'b1});
        bus_stop();
        set_lines(1'b0, 1'b0);
        check("R2", "echo after stop", {15'd0, sda_o}, 16'd0);
        set_lines(1'b0, 1'b1);
    endtask

    // R4: command-byte page write wraps in address bits 1:0
    task automatic t_cmd_page();
        proto = 2'b00;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        legacy_write(7'h7D, 4);
        legacy_read(7'h7C, 4);
        check("R4", "byte 0x7C (wrapped 4th)", {8'd0, rbuf[0]}, 16'h0044);
        check("R4", "byte 0x7D", {8'd0, rbuf[1]}, 16'h0011);
        check("R4", "byte 0x7E", {8'd0, rbuf[2]}, 16'h0022);
        check("R4", "byte 0x7F", {8'd0, rbuf[3]}, 16'h0033);
    endtask

    // R5: command-byte sequential read wraps modulo 128
    task automatic t_cmd_read_wrap();
        proto = 2'b00;
        wbuf[0] = 8'h5A;
        legacy_write(7'h00, 1);
        legacy_read(7'h7F, 2);
        check("R5", "byte 0x7F", {8'd0, rbuf[0]}, 16'h0033);
        check("R5", "wrapped to 0x00", {8'd0, rbuf[1]}, 16'h005A);
    endtask

    // R6: one address byte, select bits to 10:8, 16-byte page
    task automatic t_dev_a8();
        proto = 2'b01;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        dev_write(3'b101, 16'h000E, 3);
        dev_read(3'b101, 16'h000E, 3);
        check("R6", "0x50E", {8'd0, rbuf[0]}, 16'h00A1);
        check("R6", "0x50F", {8'd0, rbuf[1]}, 16'h00B2);
        check("R6", "0x510 not written", {8'd0, rbuf[2]}, 16'h00FF);
        dev_read(3'b101, 16'h0000, 1);
        check("R6", "page wrap to 0x500", {8'd0, rbuf[0]}, 16'h00C3);
        dev_read(3'b000, 16'h000E, 1);
        check("R6", "select 000 is other byte", {8'd0, rbuf[0]}, 16'h00FF);
    endtask

    // R7: two address bytes, 13-bit address, 16-byte page
    task automatic t_dev_a16();
        proto = 2'b10;
        wbuf[0] = 8'h6C; wbuf[1] = 8'h7D;
        dev_write(3'b000, 16'h0123, 2);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
        dev_write(3'b000, 16'h07FE, 3);
        dev_read(3'b000, 16'h0123, 2);
        check("R7", "0x123", {8'd0, rbuf[0]}, 16'h006C);
        check("R7", "0x124", {8'd0, rbuf[1]}, 16'h007D);
        dev_read(3'b000, 16'h07F0, 1);
        check("R7", "page wrap to 0x7F0", {8'd0, rbuf[0]}, 16'h0003);
        dev_read(3'b000, 16'h050E, 1);
        check("R6", "select bits seen as addr 10:8", {8'd0, rbuf[0]}, 16'h00A1);
    endtask

    // R8 and R1: sequential read across 13-bit wrap; address kept across start
    task automatic t_dev_seq();
        proto = 2'b10;
        dev_read(3'b000, 16'h1FFF, 2);
        check("R8", "0x1FFF -> index 0x7FF", {8'd0, rbuf[0]}, 16'h0002);
        check("R8", "wrap to 0x0000", {8'd0, rbuf[1]}, 16'h005A);
        dev_read(3'b000, 16'h0122, 1);
        check("R8", "0x122", {8'd0, rbuf[0]}, 16'h00FF);
        cur_read(1);
        check("R1", "current address after new start", {8'd0, rbuf[0]}, 16'h006C);
        cur_read(1);
        check("R1", "current address continues", {8'd0, rbuf[0]}, 16'h007D);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_open_bus();
        t_no_start_ignored();
        t_stop_releases();
        t_cmd_page();
        t_cmd_read_wrap();
        t_dev_a8();
        t_dev_a16();
        t_dev_seq();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule